// File: doc/BRIEF.md
# Cyclic (7,4) Single-Error Corrector

This block pairs a systematic encoder with a syndrome decoder for a seven-bit cyclic code. The code's generator polynomial is g(x) = 1 + x + x^3. Both halves compute their remainders serially, one bit per clock, in a three-stage dividing register.

The encoder accepts a 4-bit data word on a valid/ready stream. It produces a 7-bit codeword with the data in bits 6..3 and the check bits in bits 2..0. The decoder accepts a received 7-bit word on its own valid/ready stream and divides the whole word by g(x). It then maps a nonzero remainder to the single bit position that would cause it, flips that bit, and returns the 4 data bits together with status.

Both streams follow the same back-pressure rules:
- An input is taken on a clock edge where its valid and ready are both high.
- Ready stays low from that edge until the result has left the block.
- A result, once valid, holds every field stable until the edge where its ready is high.

The two channels are independent of each other.

Top module: `cyc74_codec`

## Requirements
- R1: The encoder output for data d is the codeword {d, p}: d in bits 6..3, and p in bits 2..0. Here p is the remainder of x^3·d(x) divided by 1+x+x^3, and bit i holds the coefficient of x^i. Examples: 1011→1011000, 0111→0111010, 0001→0001011, 1000→1000101, 1111→1111111, 0000→0000000.
- R2: enc_out_valid rises 7 clock edges after the edge that accepts the data. enc_in_ready is low from the accept edge until the codeword is taken.
- R3: While enc_out_valid is high and enc_out_ready is low, enc_out_valid stays high and enc_out_cw does not change.
- R4: A received word whose remainder by g(x) is zero gives dec_out_err=0, dec_out_fixed=0 and dec_out_pos=0, with dec_out_data equal to bits 6..3 of the word.
- R5: A received word that differs from a codeword in exactly bit i (i = 0 for the LSB) gives dec_out_err=1, dec_out_fixed=1, dec_out_pos=i, and dec_out_data equal to the original data. The syndromes for i = 0..6 are 001, 010, 100, 011, 110, 111 and 101. Example: 1111010 yields pos 6 and data 0111.
- R6: dec_out_valid rises 7 clock edges after the edge that accepts the word. dec_in_ready is low from the accept edge until the result is taken.
- R7: While dec_out_valid is high and dec_out_ready is low, every decoder output field stays stable.
- R8: During and right after reset, both ready outputs are high and both valid outputs are low.
- R9: Any received word that is not a codeword raises dec_out_err, including words with two flipped bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_in_valid | input | 1 | Data word offered to the encoder |
| enc_in_ready | output | 1 | Encoder can take a data word |
| enc_in_data | input | 4 | Data word |
| enc_out_valid | output | 1 | Codeword available |
| enc_out_ready | input | 1 | Consumer takes the codeword |
| enc_out_cw | output | 7 | Codeword, data in bits 6..3 |
| dec_in_valid | input | 1 | Received word offered to the decoder |
| dec_in_ready | output | 1 | Decoder can take a word |
| dec_in_word | input | 7 | Received word |
| dec_out_valid | output | 1 | Decode result available |
| dec_out_ready | input | 1 | Consumer takes the result |
| dec_out_data | output | 4 | Corrected data bits |
| dec_out_err | output | 1 | Nonzero syndrome seen |
| dec_out_fixed | output | 1 | A bit was flipped |
| dec_out_pos | output | 3 | Index of the flipped bit |

## Verification
The serial registers hold their state only across the 7-cycle run, so any corruption surfaces in the same transaction that caused it.

In the encoder, a wrong remainder stage or a miscounted shift shows up as bad check bits, or as data bits shifted out of place. It can also move the valid edge away from the seventh cycle.

In the decoder, a wrong syndrome register points the correction at the wrong bit. A clean word then gets flagged, or a single error lands at a different position and the data comes out wrong.

Every codeword is run with every single-bit error, so each syndrome value and each shift count is checked at the ports. Stalling each output tests that the held state does not drift.

// File: rtl/cyc74_pkg.sv
package cyc74_pkg;
  localparam int CW_W = 7;
  localparam int DW_W = 4;
  localparam int CK_W = CW_W - DW_W;
  // low-order terms of g(x) = 1 + x + x^3
  localparam logic [CK_W-1:0] G_LOW = 3'b011;

  typedef enum logic [1:0] {PH_IDLE, PH_RUN, PH_HOLD} phase_t;

  // encoder divide step: data bit enters at the top of the dividend
  function automatic logic [CK_W-1:0] enc_step(input logic [CK_W-1:0] r, input logic b);
    logic fb;
    fb = b ^ r[CK_W-1];
    return {r[CK_W-2:0], 1'b0} ^ (fb ? G_LOW : '0);
  endfunction

  // remainder update r*x + b mod g(x)
  function automatic logic [CK_W-1:0] rem_step(input logic [CK_W-1:0] r, input logic b);
    return {r[CK_W-2:0], b} ^ (r[CK_W-1] ? G_LOW : '0);
  endfunction

  // x^i mod g(x): syndrome of an error at position i
  function automatic logic [CK_W-1:0] pos_syn(input int i);
    logic [CK_W-1:0] r;
    r = 1;
    for (int k = 0; k < CW_W; k++)
      if (k < i) r = rem_step(r, 1'b0);
    return r;
  endfunction
endpackage

// File: rtl/cyc_serial_enc.sv
module cyc_serial_enc
  import cyc74_pkg::*;
#(
  parameter int NW = CW_W,
  parameter int KW = DW_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [KW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [NW-1:0] out_cw
);
  localparam int RW    = NW - KW;
  localparam int CNT_W = $clog2(NW);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NW - 1);
  localparam logic [CNT_W-1:0] DLIM = CNT_W'(KW);

  phase_t           ph;
  logic [KW-1:0]    dsh;
  logic [RW-1:0]    rem;
  logic [NW-1:0]    cw;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= PH_IDLE;
      dsh <= '0;
      rem <= '0;
      cw  <= '0;
      cnt <= '0;
    end else begin
      unique case (ph)
        PH_IDLE: if (in_valid) begin
          dsh <= in_data;
          rem <= '0;
          cnt <= '0;
          ph  <= PH_RUN;
        end
        PH_RUN: begin
          if (cnt < DLIM) begin
            dsh <= {dsh[KW-2:0], 1'b0};
            rem <= enc_step(rem, dsh[KW-1]);
            cw  <= {cw[NW-2:0], dsh[KW-1]};
          end else begin
            cw  <= {cw[NW-2:0], rem[RW-1]};
            rem <= {rem[RW-2:0], 1'b0};
          end
          cnt <= cnt + 1'b1;
          if (cnt == LAST) ph <= PH_HOLD;
        end
        PH_HOLD: if (out_ready) ph <= PH_IDLE;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign in_ready  = (ph == PH_IDLE);
  assign out_valid = (ph == PH_HOLD);
  assign out_cw    = cw;
endmodule

// File: rtl/cyc_serial_syn.sv
module cyc_serial_syn
  import cyc74_pkg::*;
#(
  parameter int NW = CW_W,
  parameter int RW = CK_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [NW-1:0] in_word,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [NW-1:0] out_word,
  output logic [RW-1:0] out_syn
);
  localparam int CNT_W = $clog2(NW);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NW - 1);

  phase_t           ph;
  logic [NW-1:0]    word;
  logic [NW-1:0]    sh;
  logic [RW-1:0]    syn;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= PH_IDLE;
      word <= '0;
      sh   <= '0;
      syn  <= '0;
      cnt  <= '0;
    end else begin
      unique case (ph)
        PH_IDLE: if (in_valid) begin
          word <= in_word;
          sh   <= in_word;
          syn  <= '0;
          cnt  <= '0;
          ph   <= PH_RUN;
        end
        PH_RUN: begin
          syn <= rem_step(syn, sh[NW-1]);
          sh  <= {sh[NW-2:0], 1'b0};
          cnt <= cnt + 1'b1;
          if (cnt == LAST) ph <= PH_HOLD;
        end
        PH_HOLD: if (out_ready) ph <= PH_IDLE;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign in_ready  = (ph == PH_IDLE);
  assign out_valid = (ph == PH_HOLD);
  assign out_word  = word;
  assign out_syn   = syn;
endmodule

// File: rtl/cyc_err_locate.sv
module cyc_err_locate
  import cyc74_pkg::*;
#(
  parameter int NW = CW_W,
  parameter int RW = CK_W
) (
  input  logic [RW-1:0]          syn,
  output logic [NW-1:0]          hit,
  output logic [$clog2(NW)-1:0]  pos,
  output logic                   found
);
  for (genvar i = 0; i < NW; i++) begin : g_pos
    assign hit[i] = (syn != '0) && (syn == pos_syn(i));
  end

  always_comb begin
    pos = '0;
    for (int i = 0; i < NW; i++)
      if (hit[i]) pos = ($clog2(NW))'(i);
  end

  assign found = |hit;
endmodule

// File: rtl/cyc74_codec.sv
module cyc74_codec
  import cyc74_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enc_in_valid,
  output logic            enc_in_ready,
  input  logic [DW_W-1:0] enc_in_data,
  output logic            enc_out_valid,
  input  logic            enc_out_ready,
  output logic [CW_W-1:0] enc_out_cw,
  input  logic            dec_in_valid,
  output logic            dec_in_ready,
  input  logic [CW_W-1:0] dec_in_word,
  output logic            dec_out_valid,
  input  logic            dec_out_ready,
  output logic [DW_W-1:0] dec_out_data,
  output logic            dec_out_err,
  output logic            dec_out_fixed,
  output logic [2:0]      dec_out_pos
);
  logic [CW_W-1:0] rx_word, hit, fixed_word;
  logic [CK_W-1:0] syn;

  cyc_serial_enc #(.NW(CW_W), .KW(DW_W)) u_enc (
    .clk(clk), .rst_n(rst_n),
    .in_valid(enc_in_valid), .in_ready(enc_in_ready), .in_data(enc_in_data),
    .out_valid(enc_out_valid), .out_ready(enc_out_ready), .out_cw(enc_out_cw)
  );

  cyc_serial_syn #(.NW(CW_W), .RW(CK_W)) u_syn (
    .clk(clk), .rst_n(rst_n),
    .in_valid(dec_in_valid), .in_ready(dec_in_ready), .in_word(dec_in_word),
    .out_valid(dec_out_valid), .out_ready(dec_out_ready),
    .out_word(rx_word), .out_syn(syn)
  );

  cyc_err_locate #(.NW(CW_W), .RW(CK_W)) u_loc (
    .syn(syn), .hit(hit), .pos(dec_out_pos), .found(dec_out_fixed)
  );

  assign fixed_word   = rx_word ^ hit;
  assign dec_out_data = fixed_word[CW_W-1:CK_W];
  assign dec_out_err  = |syn;
endmodule

// File: rtl/cyc74_codec_chk.sv
module cyc74_codec_chk
  import cyc74_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            enc_in_valid,
  input logic            enc_in_ready,
  input logic [DW_W-1:0] enc_in_data,
  input logic            enc_out_valid,
  input logic            enc_out_ready,
  input logic [CW_W-1:0] enc_out_cw,
  input logic            dec_in_valid,
  input logic            dec_in_ready,
  input logic [CW_W-1:0] dec_in_word,
  input logic            dec_out_valid,
  input logic            dec_out_ready,
  input logic [DW_W-1:0] dec_out_data,
  input logic            dec_out_err,
  input logic            dec_out_fixed,
  input logic [2:0]      dec_out_pos
);
  // remainder as the XOR of x^i mod g over the set bits
  function automatic logic [CK_W-1:0] word_rem(input logic [CW_W-1:0] w);
    logic [CK_W-1:0] r;
    r = '0;
    for (int i = 0; i < CW_W; i++)
      if (w[i]) r = r ^ pos_syn(i);
    return r;
  endfunction

  logic [DW_W-1:0] cap_d;
  logic [CW_W-1:0] cap_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_d <= '0;
      cap_w <= '0;
    end else begin
      if (enc_in_valid && enc_in_ready) cap_d <= enc_in_data;
      if (dec_in_valid && dec_in_ready) cap_w <= dec_in_word;
    end
  end

  a_r1_enc_data_field: assert property (@(posedge clk) disable iff (!rst_n)
    enc_out_valid |-> enc_out_cw[CW_W-1:CK_W] == cap_d);
  a_r1_enc_divisible: assert property (@(posedge clk) disable iff (!rst_n)
    enc_out_valid |-> word_rem(enc_out_cw) == '0);
  a_r2_enc_busy: assert property (@(posedge clk) disable iff (!rst_n)
    enc_out_valid |-> !enc_in_ready);
  a_r3_enc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    enc_out_valid && !enc_out_ready |=> enc_out_valid && $stable(enc_out_cw));
  a_r4_dec_clean: assert property (@(posedge clk) disable iff (!rst_n)
    dec_out_valid && word_rem(cap_w) == '0 |->
      !dec_out_err && !dec_out_fixed && dec_out_data == cap_w[CW_W-1:CK_W]);
  a_r5_dec_pos: assert property (@(posedge clk) disable iff (!rst_n)
    dec_out_valid && dec_out_fixed |-> dec_out_pos < 3'(CW_W) &&
      word_rem(cap_w) == pos_syn(int'(dec_out_pos)));
  a_r6_dec_busy: assert property (@(posedge clk) disable iff (!rst_n)
    dec_out_valid |-> !dec_in_ready);
  a_r7_dec_hold: assert property (@(posedge clk) disable iff (!rst_n)
    dec_out_valid && !dec_out_ready |=> dec_out_valid && $stable(dec_out_data) &&
      $stable(dec_out_err) && $stable(dec_out_fixed) && $stable(dec_out_pos));
  a_r9_dec_detect: assert property (@(posedge clk) disable iff (!rst_n)
    dec_out_valid && word_rem(cap_w) != '0 |-> dec_out_err);
endmodule

bind cyc74_codec cyc74_codec_chk u_chk (.*);

// File: tb/tb_cyc74_codec.sv
module tb_cyc74_codec;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enc_in_valid = 1'b0, enc_out_ready = 1'b1;
  logic [3:0] enc_in_data = '0;
  logic dec_in_valid = 1'b0, dec_out_ready = 1'b1;
  logic [6:0] dec_in_word = '0;
  logic enc_in_ready, enc_out_valid, dec_in_ready, dec_out_valid;
  logic dec_out_err, dec_out_fixed;
  logic [6:0] enc_out_cw;
  logic [3:0] dec_out_data;
  logic [2:0] dec_out_pos;

  int n_chk = 0, n_fail = 0;
  logic [6:0] r_cw;
  logic [3:0] r_d;
  logic r_e, r_f;
  logic [2:0] r_p;
  int r_lat;

  always #5 clk = ~clk;

  cyc74_codec dut (.*);

  // {data, codeword}
  localparam logic [10:0] VEC [16] = '{
    11'b0000_0000000, 11'b0001_0001011, 11'b0010_0010110, 11'b0011_0011101,
    11'b0100_0100111, 11'b0101_0101100, 11'b0110_0110001, 11'b0111_0111010,
    11'b1000_1000101, 11'b1001_1001110, 11'b1010_1010011, 11'b1011_1011000,
    11'b1100_1100010, 11'b1101_1101001, 11'b1110_1110100, 11'b1111_1111111};

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic enc_run(input logic [3:0] d);
    @(negedge clk);
    enc_in_valid = 1'b1; enc_in_data = d;
    @(posedge clk); #1;
    enc_in_valid = 1'b0;
    r_lat = 0;
    while (!enc_out_valid && r_lat < 20) begin
      @(posedge clk); #1; r_lat++;
    end
    r_cw = enc_out_cw;
    if (enc_out_ready) begin @(posedge clk); #1; end
  endtask

  task automatic dec_run(input logic [6:0] w);
    @(negedge clk);
    dec_in_valid = 1'b1; dec_in_word = w;
    @(posedge clk); #1;
    dec_in_valid = 1'b0;
    r_lat = 0;
    while (!dec_out_valid && r_lat < 20) begin
      @(posedge clk); #1; r_lat++;
    end
    r_d = dec_out_data; r_e = dec_out_err; r_f = dec_out_fixed; r_p = dec_out_pos;
    if (dec_out_ready) begin @(posedge clk); #1; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R8 reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R8 enc_in_ready in reset", enc_in_ready, 1);
    chk("R8 enc_out_valid in reset", enc_out_valid, 0);
    chk("R8 dec_in_ready in reset", dec_in_ready, 1);
    chk("R8 dec_out_valid in reset", dec_out_valid, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R8 enc_in_ready after reset", enc_in_ready, 1);
    chk("R8 dec_out_valid after reset", dec_out_valid, 0);

    // table walk: encode, then decode clean and each single-bit error
    for (int v = 0; v < 16; v++) begin
      enc_run(VEC[v][10:7]);
      chk("R1 codeword", int'(r_cw), int'(VEC[v][6:0]));
      chk("R2 encoder latency", r_lat, 7);
      for (int p = 0; p < 8; p++) begin
        logic [6:0] w;
        w = VEC[v][6:0] ^ ((p < 7) ? (7'd1 << p) : 7'd0);
        dec_run(w);
        chk("R6 decoder latency", r_lat, 7);
        chk("R4/R5 data", int'(r_d), int'(VEC[v][10:7]));
        if (p == 7) begin
          chk("R4 err clear", int'(r_e), 0);
          chk("R4 fixed clear", int'(r_f), 0);
          chk("R4 pos zero", int'(r_p), 0);
        end else begin
          chk("R5 err set", int'(r_e), 1);
          chk("R5 fixed set", int'(r_f), 1);
          chk("R5 pos", int'(r_p), p);
        end
      end
    end

    // R5 worked example
    dec_run(7'b1111010);
    chk("R5 example pos", int'(r_p), 6);
    chk("R5 example data", int'(r_d), 4'b0111);

    // R9 double errors are still flagged
    dec_run(7'b1011000 ^ 7'b0000011);
    chk("R9 double error flagged", int'(r_e), 1);
    dec_run(7'b0111010 ^ 7'b1000001);
    chk("R9 double error flagged", int'(r_e), 1);

    // R3 encoder back-pressure
    enc_out_ready = 1'b0;
    enc_run(4'b0110);
    chk("R2 encoder latency stalled", r_lat, 7);
    for (int k = 0; k < 5; k++) begin
      @(posedge clk); #1;
      chk("R3 valid held", enc_out_valid, 1);
      chk("R3 cw held", int'(enc_out_cw), 7'b0110001);
      chk("R2 in_ready low while held", enc_in_ready, 0);
    end
    @(negedge clk); enc_out_ready = 1'b1;
    @(posedge clk); #1;
    chk("R3 released", enc_out_valid, 0);
    chk("R2 in_ready back", enc_in_ready, 1);

    // R7 decoder back-pressure
    dec_out_ready = 1'b0;
    dec_run(7'b1101001 ^ 7'b0001000);
    for (int k = 0; k < 5; k++) begin
      @(posedge clk); #1;
      chk("R7 valid held", dec_out_valid, 1);
      chk("R7 data held", int'(dec_out_data), 4'b1101);
      chk("R7 pos held", int'(dec_out_pos), 3);
      chk("R7 err held", int'(dec_out_err), 1);
      chk("R6 in_ready low while held", dec_in_ready, 0);
    end
    @(negedge clk); dec_out_ready = 1'b1;
    @(posedge clk); #1;
    chk("R7 released", dec_out_valid, 0);

    // R8 reset in mid-run
    @(negedge clk); enc_in_valid = 1'b1; enc_in_data = 4'b1111;
    @(posedge clk); #1; enc_in_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b0;
    #1;
    chk("R8 enc_in_ready on mid-run reset", enc_in_ready, 1);
    chk("R8 enc_out_valid on mid-run reset", enc_out_valid, 0);
    @(negedge clk); rst_n = 1'b1;
    enc_run(4'b0001);
    chk("R1 after reset", int'(r_cw), 7'b0001011);

    finish_run();
  end
endmodule